// File: doc/BRIEF.md
# Message-Interrupt Doorbell Decoder with Vector Table

This block keeps a small table of message-interrupt allocations, one entry per requesting device, keyed by the device's 32-bit configuration address. A management port takes one command at a time. A command can enable an allocation, reuse an existing allocation or release one, or it can query the global interrupt number of a device vector. When an enable succeeds, the block streams out the message address that the device must be programmed with. Plain MSI gets one address. MSI-X gets one address per vector.

The second port is a write-only doorbell window of SLOTS x 64 KiB. Each write is split into a table slot and a vector. The slot comes from the address bits at 16 and above. The vector is address bits 15:2 ORed with the write data, so the same decoder serves both MSI and MSI-X. The block then emits a one-cycle interrupt pulse carrying the slot's base interrupt number plus the vector. Global interrupt numbers come from a simple bump allocator that starts at IRQ_FIRST and may not pass IRQ_LIMIT.

Top module: `msi_doorbell_table`

## Requirements
- R1: After reset, cmd_ready is 1 and rsp_valid, msg_valid and irq_pulse are 0. The table is empty, so a query of any device returns status 8'hFF.
- R2: On a change command, cmd_func 1 or 3 selects plain MSI and reports rsp_type 1. cmd_func 4 selects MSI-X and reports rsp_type 2. Any other value returns status 8'hFD and leaves the table unchanged.
- R3: An enable for a device with no entry takes the first empty slot in index order. Its base is the allocator value, which starts at IRQ_FIRST and then advances by the granted count. One cycle after acceptance, rsp_valid carries status 8'h00, the count, cmd_seq+1 and the type.
- R4: An enable for an existing entry with the same count reuses that entry's base and does not advance the allocator.
- R5: An enable for an existing entry with a different count returns status 8'hFF.
- R6: A release (count 0) of a device with no entry returns 8'hFF. Otherwise it returns 8'h00 with rsp_count 0 and the entry stays in the table.
- R7: An enable that needs a new slot returns 8'hFF and allocates nothing in two cases: when all slots are in use, or when the allocator plus the count would exceed IRQ_LIMIT.
- R8: A query (cmd_query=1) returns status 8'h00, rsp_irq equal to the entry base plus cmd_vec, and rsp_edge=1. A query of an unknown device returns 8'hFF.
- R9: After a successful enable, msg_valid is high for one cycle per address, starting in the cycle of the response. MSI gets a single address WIN_BASE|(slot<<16). MSI-X gets count addresses WIN_BASE|(slot<<16)|(i<<2) for i=0..count-1. cmd_ready is 0 while addresses stream.
- R10: A doorbell write selects slot db_addr[WIN_W-1:16] and vector db_addr[15:2]|db_data. One cycle later, irq_pulse is high for that cycle with irq_num equal to the slot base plus the vector.
- R11: A doorbell write to a slot whose count is zero raises no pulse.
- R12: A doorbell write in the same cycle as an enable that creates the target slot is decoded against the table as it was before that enable, so it raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Management command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_query | input | 1 | 1 = query interrupt number, 0 = change allocation |
| cmd_func | input | 3 | Change function code |
| cmd_cfg | input | CFG_W | Device configuration address |
| cmd_count | input | CNT_W | Requested vector count, 0 = release |
| cmd_seq | input | 32 | Caller sequence number |
| cmd_vec | input | IRQ_W | Device vector for a query |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_status | output | 8 | 8'h00 ok, 8'hFF hardware error, 8'hFD parameter error |
| rsp_count | output | CNT_W | Granted count |
| rsp_seq | output | 32 | Sequence number plus one |
| rsp_type | output | 2 | 1 MSI, 2 MSI-X, 0 otherwise |
| rsp_irq | output | IRQ_W | Queried interrupt number |
| rsp_edge | output | 1 | Source is edge-triggered |
| msg_valid | output | 1 | Message address beat |
| msg_index | output | CNT_W | Vector index of the beat |
| msg_addr | output | MSG_W | Message address for the device |
| db_valid | input | 1 | Doorbell write |
| db_addr | input | WIN_W | Offset inside the doorbell window |
| db_data | input | IRQ_W | Doorbell write data |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_num | output | IRQ_W | Global interrupt number of the pulse |

## Verification
A doorbell decode and a management update can land on the same clock edge. This matters most when the update is an enable that fills the very slot the doorbell addresses. The bench issues an enable for a new device and, in the same cycle, a doorbell to the slot that enable will take. It expects no pulse from that doorbell. A second doorbell one cycle later must then produce the new base plus the vector. Doorbells to already-populated slots are also rung while address streams are active, to show that decode is independent of the command path.

// File: rtl/msi_dbl_pkg.sv
package msi_dbl_pkg;

   localparam logic [7:0] ST_OK    = 8'h00;
   localparam logic [7:0] ST_HWERR = 8'hFF;
   localparam logic [7:0] ST_PARAM = 8'hFD;

   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_MSI  = 2'd1,
      KIND_MSIX = 2'd2
   } msg_kind_e;

   typedef enum logic [2:0] {
      FN_PROBE    = 3'd0,
      FN_SET_ANY  = 3'd1,
      FN_RESTART  = 3'd2,
      FN_SET_MSI  = 3'd3,
      FN_SET_MSIX = 3'd4
   } chg_fn_e;

   function automatic msg_kind_e kind_of(input logic [2:0] fn);
      case (fn)
         FN_SET_ANY, FN_SET_MSI: kind_of = KIND_MSI;
         FN_SET_MSIX:            kind_of = KIND_MSIX;
         default:                kind_of = KIND_NONE;
      endcase
   endfunction

endpackage

// File: rtl/msi_slot_scan.sv
module msi_slot_scan #(
   parameter int SLOTS = 8,
   parameter int CFG_W = 32,
   parameter int CNT_W = 8,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic [CFG_W-1:0] cfg_tab [SLOTS],
   input  logic [CNT_W-1:0] cnt_tab [SLOTS],
   input  logic [CFG_W-1:0] key,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic             free_ok,
   output logic [IDX_W-1:0] free_idx
);

   // Ordered scan: stops at the first empty entry.
   always_comb begin
      logic stop;
      stop     = 1'b0;
      hit      = 1'b0;
      hit_idx  = '0;
      free_ok  = 1'b0;
      free_idx = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (!stop) begin
            if (cnt_tab[i] == '0) begin
               stop     = 1'b1;
               free_ok  = 1'b1;
               free_idx = IDX_W'(i);
            end else if (!hit && cfg_tab[i] == key) begin
               hit     = 1'b1;
               hit_idx = IDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen #(
   parameter int          SLOTS    = 8,
   parameter int          CNT_W    = 8,
   parameter int          MSG_W    = 32,
   parameter logic [31:0] WIN_BASE = 32'h8000_0000,
   localparam int         IDX_W    = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] start_slot,
   input  logic             start_multi,
   input  logic [CNT_W-1:0] start_count,
   output logic             active,
   output logic [CNT_W-1:0] idx,
   output logic [MSG_W-1:0] addr
);

   logic [IDX_W-1:0] slot_q;
   logic [CNT_W-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         slot_q <= '0;
         last_q <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
         slot_q <= start_slot;
         last_q <= start_multi ? start_count - 1'b1 : '0;
      end else if (active) begin
         if (idx == last_q) active <= 1'b0;
         else               idx    <= idx + 1'b1;
      end
   end

   always_comb begin
      addr = MSG_W'(WIN_BASE) | (MSG_W'(slot_q) << 16) | (MSG_W'(idx) << 2);
   end

endmodule

// File: rtl/msi_doorbell_dec.sv
module msi_doorbell_dec #(
   parameter int  SLOTS = 8,
   parameter int  CNT_W = 8,
   parameter int  IRQ_W = 16,
   parameter int  WIN_W = 19,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             db_valid,
   input  logic [WIN_W-1:0] db_addr,
   input  logic [IRQ_W-1:0] db_data,
   input  logic [CNT_W-1:0] cnt_tab  [SLOTS],
   input  logic [IRQ_W-1:0] base_tab [SLOTS],
   output logic             irq_pulse,
   output logic [IRQ_W-1:0] irq_num
);

   logic [IDX_W-1:0] slot;
   logic [IRQ_W-1:0] vec;
   logic             live;
   wire              unused_lsb = ^db_addr[1:0];

   assign slot = db_addr[WIN_W-1:16];
   assign vec  = IRQ_W'(db_addr[15:2]) | db_data;
   assign live = (cnt_tab[slot] != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_pulse <= 1'b0;
         irq_num   <= '0;
      end else begin
         irq_pulse <= db_valid && live;
         if (db_valid && live) irq_num <= base_tab[slot] + vec;
      end
   end

endmodule

// File: rtl/msi_doorbell_table.sv
module msi_doorbell_table
   import msi_dbl_pkg::*;
#(
   parameter int          SLOTS     = 8,
   parameter int          CFG_W     = 32,
   parameter int          CNT_W     = 8,
   parameter int          IRQ_W     = 16,
   parameter int          MSG_W     = 32,
   parameter int          WIN_W     = $clog2(SLOTS) + 16,
   parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
   parameter int          IRQ_FIRST = 'h1000,
   parameter int          IRQ_LIMIT = 'h1040
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic             cmd_query,
   input  logic [2:0]       cmd_func,
   input  logic [CFG_W-1:0] cmd_cfg,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic [31:0]      cmd_seq,
   input  logic [IRQ_W-1:0] cmd_vec,
   output logic             rsp_valid,
   output logic [7:0]       rsp_status,
   output logic [CNT_W-1:0] rsp_count,
   output logic [31:0]      rsp_seq,
   output logic [1:0]       rsp_type,
   output logic [IRQ_W-1:0] rsp_irq,
   output logic             rsp_edge,
   output logic             msg_valid,
   output logic [CNT_W-1:0] msg_index,
   output logic [MSG_W-1:0] msg_addr,
   input  logic             db_valid,
   input  logic [WIN_W-1:0] db_addr,
   input  logic [IRQ_W-1:0] db_data,
   output logic             irq_pulse,
   output logic [IRQ_W-1:0] irq_num
);

   localparam int IDX_W = $clog2(SLOTS);
   localparam int SUM_W = IRQ_W + 1;

   // ---------------- elaboration checks ----------------
   if (SLOTS < 2 || (1 << IDX_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (WIN_W != IDX_W + 16) begin : g_bad_win
      $error("WIN_W must equal log2(SLOTS)+16");
   end
   if (IRQ_W < 14 || IRQ_W > 31) begin : g_bad_irq
      $error("IRQ_W must lie in 14..31");
   end
   if (CNT_W < 1 || CNT_W > 14) begin : g_bad_cnt
      $error("CNT_W must lie in 1..14");
   end
   if (MSG_W < WIN_W || MSG_W > 32) begin : g_bad_msg
      $error("MSG_W must cover the window and fit 32 bits");
   end
   if (IRQ_LIMIT < IRQ_FIRST || IRQ_LIMIT >= (1 << IRQ_W)) begin : g_bad_lim
      $error("IRQ_LIMIT out of range");
   end

   // ---------------- table storage ----------------
   logic [CFG_W-1:0] cfg_tab  [SLOTS];
   logic [CNT_W-1:0] cnt_tab  [SLOTS];
   logic [IRQ_W-1:0] base_tab [SLOTS];
   logic [IRQ_W-1:0] next_base;

   logic             accept;
   logic             tab_wr;
   logic [IDX_W-1:0] tab_idx;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_tab[g]  <= '0;
            cnt_tab[g]  <= '0;
            base_tab[g] <= '0;
         end else if (accept && tab_wr && tab_idx == IDX_W'(g)) begin
            cfg_tab[g]  <= cmd_cfg;
            cnt_tab[g]  <= cmd_count;
            base_tab[g] <= next_base;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                next_base <= IRQ_W'(IRQ_FIRST);
      else if (accept && tab_wr) next_base <= next_base + IRQ_W'(cmd_count);
   end

   // ---------------- lookup ----------------
   logic             hit, free_ok;
   logic [IDX_W-1:0] hit_idx, free_idx;

   msi_slot_scan #(.SLOTS(SLOTS), .CFG_W(CFG_W), .CNT_W(CNT_W)) u_scan (
      .cfg_tab (cfg_tab),
      .cnt_tab (cnt_tab),
      .key     (cmd_cfg),
      .hit     (hit),
      .hit_idx (hit_idx),
      .free_ok (free_ok),
      .free_idx(free_idx)
   );

   // ---------------- command decision ----------------
   msg_kind_e        kind;
   logic [SUM_W-1:0] new_sum;
   logic             room;
   logic             en_ok;
   logic [7:0]       d_status;
   logic [IRQ_W-1:0] d_irq;
   logic             d_edge;
   logic [IDX_W-1:0] gen_slot;
   logic             gen_active;

   assign kind      = kind_of(cmd_func);
   assign new_sum   = {1'b0, next_base} + SUM_W'(cmd_count);
   assign room      = new_sum <= SUM_W'(IRQ_LIMIT);
   assign cmd_ready = !gen_active;
   assign accept    = cmd_valid && cmd_ready;

   always_comb begin
      d_status = ST_HWERR;
      d_irq    = '0;
      d_edge   = 1'b0;
      en_ok    = 1'b0;
      tab_wr   = 1'b0;
      tab_idx  = free_idx;
      gen_slot = hit_idx;
      if (cmd_query) begin
         if (hit) begin
            d_status = ST_OK;
            d_irq    = base_tab[hit_idx] + cmd_vec;
            d_edge   = 1'b1;
         end
      end else if (kind == KIND_NONE) begin
         d_status = ST_PARAM;
      end else if (cmd_count == '0) begin
         if (hit) d_status = ST_OK;
      end else if (hit) begin
         en_ok = (cnt_tab[hit_idx] == cmd_count);
      end else if (free_ok && room) begin
         en_ok    = 1'b1;
         tab_wr   = 1'b1;
         gen_slot = free_idx;
      end
      if (en_ok) d_status = ST_OK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= '0;
         rsp_count  <= '0;
         rsp_seq    <= '0;
         rsp_type   <= '0;
         rsp_irq    <= '0;
         rsp_edge   <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_status <= d_status;
            rsp_count  <= en_ok ? cmd_count : '0;
            rsp_seq    <= en_ok ? cmd_seq + 32'd1 : '0;
            rsp_type   <= en_ok ? kind : KIND_NONE;
            rsp_irq    <= d_irq;
            rsp_edge   <= d_edge;
         end
      end
   end

   // ---------------- address streaming ----------------
   msi_msg_gen #(.SLOTS(SLOTS), .CNT_W(CNT_W), .MSG_W(MSG_W), .WIN_BASE(WIN_BASE)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept && en_ok),
      .start_slot (gen_slot),
      .start_multi(kind == KIND_MSIX),
      .start_count(cmd_count),
      .active     (gen_active),
      .idx        (msg_index),
      .addr       (msg_addr)
   );
   assign msg_valid = gen_active;

   // ---------------- doorbell ----------------
   msi_doorbell_dec #(.SLOTS(SLOTS), .CNT_W(CNT_W), .IRQ_W(IRQ_W), .WIN_W(WIN_W)) u_db (
      .clk      (clk),
      .rst_n    (rst_n),
      .db_valid (db_valid),
      .db_addr  (db_addr),
      .db_data  (db_data),
      .cnt_tab  (cnt_tab),
      .base_tab (base_tab),
      .irq_pulse(irq_pulse),
      .irq_num  (irq_num)
   );

endmodule

// File: rtl/msi_doorbell_table_chk.sv
module msi_doorbell_table_chk #(
   parameter int CNT_W = 8,
   parameter int MSG_W = 32,
   parameter int WIN_W = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [31:0]      cmd_seq,
   input logic             rsp_valid,
   input logic [7:0]       rsp_status,
   input logic [31:0]      rsp_seq,
   input logic [1:0]       rsp_type,
   input logic             rsp_edge,
   input logic             msg_valid,
   input logic [CNT_W-1:0] msg_index,
   input logic [MSG_W-1:0] msg_addr,
   input logic             db_valid,
   input logic             irq_pulse
);

   wire unused_hi = ^msg_addr;

   AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(cmd_valid && cmd_ready)); // R3

   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_status == 8'h00 || rsp_status == 8'hFF || rsp_status == 8'hFD)); // R2

   AST_SEQ_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_type != 2'd0 |-> rsp_seq == $past(cmd_seq) + 32'd1); // R3

   AST_EDGE_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_edge |-> rsp_status == 8'h00); // R8

   AST_BUSY_WHILE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !cmd_ready); // R9

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && $past(msg_valid) |->
         msg_addr[15:2] == $past(msg_addr[15:2]) + 14'd1 &&
         msg_addr[WIN_W-1:16] == $past(msg_addr[WIN_W-1:16]) &&
         msg_index == $past(msg_index) + 1'b1); // R9

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_addr[1:0] == 2'b00); // R9

   AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(db_valid)); // R10

endmodule

bind msi_doorbell_table msi_doorbell_table_chk #(
   .CNT_W(CNT_W), .MSG_W(MSG_W), .WIN_W(WIN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_seq   (cmd_seq),
   .rsp_valid (rsp_valid),
   .rsp_status(rsp_status),
   .rsp_seq   (rsp_seq),
   .rsp_type  (rsp_type),
   .rsp_edge  (rsp_edge),
   .msg_valid (msg_valid),
   .msg_index (msg_index),
   .msg_addr  (msg_addr),
   .db_valid  (db_valid),
   .irq_pulse (irq_pulse)
);

// File: tb/sim_msi_doorbell_table.sv
`timescale 1ns/1ps
module sim_msi_doorbell_table;

   localparam logic [31:0] WB = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_query = 1'b0;
   logic [2:0]  cmd_func = '0;
   logic [31:0] cmd_cfg = '0, cmd_seq = '0;
   logic [7:0]  cmd_count = '0;
   logic [15:0] cmd_vec = '0;
   logic        cmd_ready, rsp_valid, rsp_edge, msg_valid, irq_pulse;
   logic [7:0]  rsp_status, rsp_count, msg_index;
   logic [31:0] rsp_seq, msg_addr;
   logic [1:0]  rsp_type;
   logic [15:0] rsp_irq, irq_num;
   logic        db_valid = 1'b0;
   logic [18:0] db_addr = '0;
   logic [15:0] db_data = '0;

   int n_chk = 0, n_bad = 0;
   logic [31:0] beats [64];
   int n_beats;
   logic [7:0]  r_status, r_count;
   logic [31:0] r_seq;
   logic [1:0]  r_type;
   logic [15:0] r_irq;
   logic        r_edge;

   always #2 clk = ~clk;

   msi_doorbell_table u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_query(cmd_query), .cmd_func(cmd_func), .cmd_cfg(cmd_cfg),
      .cmd_count(cmd_count), .cmd_seq(cmd_seq), .cmd_vec(cmd_vec),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_count(rsp_count),
      .rsp_seq(rsp_seq), .rsp_type(rsp_type), .rsp_irq(rsp_irq), .rsp_edge(rsp_edge),
      .msg_valid(msg_valid), .msg_index(msg_index), .msg_addr(msg_addr),
      .db_valid(db_valid), .db_addr(db_addr), .db_data(db_data),
      .irq_pulse(irq_pulse), .irq_num(irq_num)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // Issues one command; response is sampled at the negedge after acceptance.
   task automatic do_cmd(input logic q, input logic [2:0] fn, input logic [31:0] cfg,
                         input logic [7:0] cnt, input logic [31:0] seq, input logic [15:0] vec);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_query = q; cmd_func = fn; cmd_cfg = cfg; cmd_count = cnt;
      cmd_seq = seq; cmd_vec = vec; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R3 rsp_valid", rsp_valid, 1'b1);
      r_status = rsp_status; r_count = rsp_count; r_seq = rsp_seq;
      r_type = rsp_type; r_irq = rsp_irq; r_edge = rsp_edge;
      n_beats = 0;
      while (msg_valid) begin
         if (n_beats < 64) beats[n_beats] = msg_addr;
         n_beats++;
         @(negedge clk);
      end
   endtask

   task automatic enable_ok(input string tag, input logic [2:0] fn, input logic [31:0] cfg,
                            input logic [7:0] cnt, input logic [31:0] seq, input int slot);
      logic multi;
      multi = (fn == 3'd4);
      do_cmd(1'b0, fn, cfg, cnt, seq, 16'd0);
      chk({tag, " status"}, r_status, 8'h00);
      chk({tag, " count"}, r_count, cnt);
      chk({tag, " seq"}, r_seq, seq + 1);
      chk({tag, " R2 type"}, r_type, multi ? 2'd2 : 2'd1);
      chk({tag, " R9 beats"}, n_beats, multi ? cnt : 1);
      for (int i = 0; i < n_beats && i < 64; i++)
         chk({tag, " R9 addr"}, beats[i], WB | (32'(slot) << 16) | (multi ? 32'(i) << 2 : 32'd0));
   endtask

   task automatic expect_status(input string tag, input logic [2:0] fn, input logic [31:0] cfg,
                                input logic [7:0] cnt, input logic [7:0] st);
      do_cmd(1'b0, fn, cfg, cnt, 32'd5, 16'd0);
      chk({tag, " status"}, r_status, st);
      chk({tag, " no beats"}, n_beats, 0);
   endtask

   task automatic query(input string tag, input logic [31:0] cfg, input logic [15:0] vec,
                        input logic [7:0] st, input logic [15:0] irq);
      do_cmd(1'b1, 3'd0, cfg, 8'd0, 32'd0, vec);
      chk({tag, " status"}, r_status, st);
      if (st == 8'h00) begin
         chk({tag, " irq"}, r_irq, irq);
         chk({tag, " edge"}, r_edge, 1'b1);
      end
   endtask

   task automatic ring(input string tag, input int slot, input logic [13:0] v,
                       input logic [15:0] data, input logic exp_p, input logic [15:0] exp_n);
      @(negedge clk);
      db_addr = {3'(slot), v, 2'b00}; db_data = data; db_valid = 1'b1;
      @(negedge clk);
      db_valid = 1'b0;
      chk({tag, " pulse"}, irq_pulse, exp_p);
      if (exp_p) chk({tag, " irq_num"}, irq_num, exp_n);
      @(negedge clk);
      chk({tag, " pulse single"}, irq_pulse, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 cmd_ready", cmd_ready, 1'b1);
      chk("R1 rsp_valid", rsp_valid, 1'b0);
      chk("R1 msg_valid", msg_valid, 1'b0);
      chk("R1 irq_pulse", irq_pulse, 1'b0);
      query("R1 empty query", 32'h100, 16'd0, 8'hFF, 16'd0);
   endtask

   task automatic t_func_codes();
      expect_status("R2 bad func 2", 3'd2, 32'h100, 8'd4, 8'hFD);
      expect_status("R2 bad func 0", 3'd0, 32'h100, 8'd4, 8'hFD);
      query("R2 table untouched", 32'h100, 16'd0, 8'hFF, 16'd0);
   endtask

   task automatic t_enable();
      enable_ok("R3 msix slot0", 3'd4, 32'h0800, 8'd4, 32'd7, 0);   // base 0x1000
      enable_ok("R3 msi slot1", 3'd3, 32'h1000, 8'd1, 32'd0, 1);    // base 0x1004
      enable_ok("R3 msi fn1 slot2", 3'd1, 32'h1800, 8'd2, 32'd9, 2); // base 0x1005
      query("R3 slot2 base", 32'h1800, 16'd0, 8'h00, 16'h1005);
   endtask

   task automatic t_reuse_release();
      enable_ok("R4 reuse", 3'd4, 32'h0800, 8'd4, 32'd20, 0);
      query("R4 base kept", 32'h0800, 16'd3, 8'h00, 16'h1003);
      expect_status("R5 count mismatch", 3'd4, 32'h0800, 8'd2, 8'hFF);
      do_cmd(1'b0, 3'd3, 32'h0800, 8'd0, 32'd1, 16'd0);
      chk("R6 release status", r_status, 8'h00);
      chk("R6 release count", r_count, 8'd0);
      query("R6 entry kept", 32'h0800, 16'd1, 8'h00, 16'h1001);
      expect_status("R6 release unknown", 3'd3, 32'h7000, 8'd0, 8'hFF);
   endtask

   task automatic t_query();
      query("R8 query slot2", 32'h1800, 16'd1, 8'h00, 16'h1006);
      query("R8 query unknown", 32'h9999, 16'd1, 8'hFF, 16'd0);
   endtask

   task automatic t_doorbell();
      ring("R10 msix vec2", 0, 14'd2, 16'd0, 1'b1, 16'h1002);
      ring("R10 msi data1", 2, 14'd0, 16'd1, 1'b1, 16'h1006);
      ring("R10 or addr data", 0, 14'd1, 16'd2, 1'b1, 16'h1003);
      ring("R11 empty slot", 5, 14'd0, 16'd0, 1'b0, 16'd0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_query = 1'b0; cmd_func = 3'd4; cmd_cfg = 32'h2000; cmd_count = 8'd2;
      cmd_seq = 32'd0; cmd_valid = 1'b1;
      db_addr = {3'd3, 14'd1, 2'b00}; db_data = 16'd0; db_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; db_valid = 1'b0;
      chk("R12 rsp ok", rsp_status, 8'h00);
      chk("R12 no pulse", irq_pulse, 1'b0);
      ring("R12 after enable", 3, 14'd1, 16'd0, 1'b1, 16'h1008);  // base 0x1007
   endtask

   task automatic t_limits();
      expect_status("R7 irq limit", 3'd4, 32'h3000, 8'd64, 8'hFF);
      enable_ok("R7 slot4 after refusal", 3'd3, 32'h3000, 8'd1, 32'd0, 4); // 0x1009
      query("R7 slot4 base", 32'h3000, 16'd0, 8'h00, 16'h1009);
      enable_ok("R7 slot5", 3'd3, 32'h3800, 8'd1, 32'd0, 5);
      enable_ok("R7 slot6", 3'd3, 32'h4000, 8'd1, 32'd0, 6);
      enable_ok("R7 slot7", 3'd3, 32'h4800, 8'd1, 32'd0, 7);
      expect_status("R7 table full", 3'd3, 32'h5000, 8'd1, 8'hFF);
      ring("R10 slot7", 7, 14'd0, 16'd0, 1'b1, 16'h100C);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_func_codes();
      t_enable();
      t_reuse_release();
      t_query();
      t_doorbell();
      t_same_cycle();
      t_limits();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule